// File: doc/BRIEF.md
# I2C Controller Register and FIFO Front-End

This block is the software-facing half of an I2C master. A 32-bit register bus reaches eleven word registers. Through them software can:

- set the bus clock divider, the target address, the byte count and the command word;
- load a 16-entry transmit byte queue;
- drain a 16-entry receive byte queue;
- watch and clear the latched status flags.

The bus sequencer (the SCL/SDA engine, outside this block) receives the configuration as level outputs and the command as a one-cycle strobe. It pulls transmit bytes with a request line and pushes received bytes back. It reports completion, NACK, bus error, arbitration loss and stop detection as single-cycle event inputs. The interrupt line is the pending flag gated by its enable.

A single enable bit in the control register governs all live state. While it is low, both queues, every latched flag, the received-byte counter and both queue-flush sequencers are held cleared. The configuration registers keep their values.

Each queue has its own flush sequencer, built as a three-state machine:

- FL_IDLE goes to FL_CLEAR when software sets that queue's flush bit.
- FL_CLEAR always goes to FL_HOLD.
- FL_HOLD always goes back to FL_IDLE.
- Any state goes to FL_IDLE while the controller is disabled.

The queue is cleared on the clock edges taken in FL_CLEAR and in FL_HOLD. The flush bit reads 1 while the sequencer is in either of those states.

Top module: `i2c_regfront`

## Requirements
- R1: After reset, every register reads zero, irq_o, seq_go and tx_valid are low, and tx_byte is zero. A register is selected by bus_addr[5:2] only when bus_addr[1:0] is zero. The word indexes are: 0 control, 1 divider, 2 status, 3 target address, 4 transmit data, 5 receive data, 6 command, 7 queue control, 8 queue status, 9 byte count, 10 received count.
- R2: While control bit 7 (enable) is 0, both queues stay empty, and status, the NACK flag and the received count stay zero. A write to transmit data is lost.
- R3: Writes to transmit data queue byte wdata[7:0] in order. tx_byte shows the oldest byte, or zero when the queue is empty, and tx_valid is high when the queue is not empty. A cycle with tx_req high removes one byte. Queue status bits 23:16 give the transmit level.
- R4: When the transmit queue holds 16 bytes, a write to transmit data is dropped, even in a cycle that also removes a byte. Queue status bit 5 reads 1 while the queue is full.
- R5: rx_push stores rx_byte in order. A read of receive data returns the oldest byte and removes it, and returns zero when the queue is empty. Queue status bit 2 reads 1 while the receive queue is not empty, and bits 15:8 give its level.
- R6: An rx_push when the receive queue holds 16 bytes is dropped and does not advance the received count.
- R7: Writing 1 to queue control bit 1 (receive) or bit 2 (transmit) empties that queue. The bit reads 1 for the two cycles after the write, then 0. Bytes offered during those two cycles are lost.
- R8: Queue control bit 0 is stored, reads back, and drives seq_ignore_nack.
- R9: Status bits 1 (bus error), 3 (arbitration lost) and 4 (stop seen) are set by their events. Status bit 2 (pending) is set by ev_done, ev_nack or ev_bus_err. Writing 1 to any of these bits clears it, and writing all zeros clears them all and the NACK flag. A setting event wins over a clear in the same cycle. Status bit 6 reads bus_busy live.
- R10: irq_o is high exactly when the pending flag and control bit 5 are both 1.
- R11: While enabled, a write to the command word (bits 15:0) raises seq_go for the next cycle only, and resets the received count. The received count then advances on every accepted received byte.
- R12: The divider (wdata[7:0]), target address and byte count registers read back their low 8 bits and drive seq_clk_div, seq_target and seq_byte_cnt.
- R13: ev_nack sets queue status bit 1, which stays set until status is written with all zeros or the controller is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_o | output | 1 | Interrupt request |
| seq_en | output | 1 | Controller enabled |
| seq_clk_div | output | 8 | SCL divider (period = 16 × divider) |
| seq_target | output | 8 | Target address byte |
| seq_byte_cnt | output | 8 | Transfer byte count |
| seq_cmd | output | 16 | Command word |
| seq_go | output | 1 | One-cycle command strobe |
| seq_ignore_nack | output | 1 | Continue past a NACK |
| tx_req | input | 1 | Sequencer takes a transmit byte |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | Transmit queue not empty |
| rx_push | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| ev_done | input | 1 | Transfer finished |
| ev_nack | input | 1 | NACK seen |
| ev_bus_err | input | 1 | Bus error seen |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_stop | input | 1 | Stop condition seen |
| bus_busy | input | 1 | Bus busy level |

## Verification
The queues are driven in several patterns:

- partial fills drained in order, which show that ordering and levels are right;
- fills past 16 entries, which show that overflow bytes are dropped rather than overwriting older ones;
- reads of an empty receive queue, which show the zero return;
- flushes with traffic offered during the two busy cycles, which show the exact length of the clear window.

The status flags are raised by each event in turn, then cleared by single-bit writes and by the all-zero write. This tells write-one-to-clear apart from clear-all. Disabling the controller with data queued separates the live state from the configuration that survives.

// File: rtl/i2c_regfront_pkg.sv
package i2c_regfront_pkg;

    // Word indexes on bus_addr[5:2]
    localparam logic [3:0] IX_CTL   = 4'd0;
    localparam logic [3:0] IX_DIV   = 4'd1;
    localparam logic [3:0] IX_STAT  = 4'd2;
    localparam logic [3:0] IX_TADR  = 4'd3;
    localparam logic [3:0] IX_TXD   = 4'd4;
    localparam logic [3:0] IX_RXD   = 4'd5;
    localparam logic [3:0] IX_CMD   = 4'd6;
    localparam logic [3:0] IX_FCTL  = 4'd7;
    localparam logic [3:0] IX_FSTAT = 4'd8;
    localparam logic [3:0] IX_DCNT  = 4'd9;
    localparam logic [3:0] IX_RCNT  = 4'd10;

    typedef enum logic [1:0] {
        FL_IDLE  = 2'd0,
        FL_CLEAR = 2'd1,
        FL_HOLD  = 2'd2
    } flush_state_e;

    typedef struct packed {
        logic nack;
        logic stop;
        logic arb;
        logic pend;
        logic berr;
    } stat_t;

endpackage

// File: rtl/i2c_regfront_fifo.sv
module i2c_regfront_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic             empty,
    output logic             full,
    output logic [LVL_W-1:0] level
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [LVL_W-1:0] count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == LVL_W'(DEPTH));
    assign level   = count;
    assign do_push = push & ~full & ~clr;
    assign do_pop  = pop & ~empty & ~clr;
    assign dout    = empty ? '0 : mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            count <= count + LVL_W'(do_push) - LVL_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LVL_W'(DEPTH)); // R4
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop && !clr |=> full); // R4
    AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        empty && !push |=> empty); // R5

endmodule

// File: rtl/i2c_regfront_flush.sv
module i2c_regfront_flush
    import i2c_regfront_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic start,
    output logic busy
);

    flush_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FL_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (hold) begin
            nxt = FL_IDLE;
        end else begin
            unique case (state)
                FL_IDLE:  if (start) nxt = FL_CLEAR;
                FL_CLEAR: nxt = FL_HOLD;
                FL_HOLD:  nxt = FL_IDLE;
                default:  nxt = FL_IDLE;
            endcase
        end
    end

    always_comb begin
        busy = (state != FL_IDLE);
    end

    AST_FLUSH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        state == FL_CLEAR && !hold |=> state == FL_HOLD); // R7

endmodule

// File: rtl/i2c_regfront.sv
module i2c_regfront
    import i2c_regfront_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CMD_W      = 16,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
    localparam int NCH       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [5:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             irq_o,
    output logic             seq_en,
    output logic [7:0]       seq_clk_div,
    output logic [7:0]       seq_target,
    output logic [7:0]       seq_byte_cnt,
    output logic [CMD_W-1:0] seq_cmd,
    output logic             seq_go,
    output logic             seq_ignore_nack,
    input  logic             tx_req,
    output logic [7:0]       tx_byte,
    output logic             tx_valid,
    input  logic             rx_push,
    input  logic [7:0]       rx_byte,
    input  logic             ev_done,
    input  logic             ev_nack,
    input  logic             ev_bus_err,
    input  logic             ev_arb_lost,
    input  logic             ev_stop,
    input  logic             bus_busy
);

    // Channel 0 is receive, channel 1 is transmit; flush bit = channel + 1
    localparam int CH_RX = 0;
    localparam int CH_TX = 1;

    logic             ctl_en, ctl_ie, nib_q, go_q;
    logic [7:0]       div_q, tadr_q, dcnt_q, rcnt_q;
    logic [CMD_W-1:0] cmd_q;
    stat_t            st_q, st_nxt;

    logic       aligned, wr_any, rd_any;
    logic [3:0] idx;

    logic [NCH-1:0] f_clr, f_push, f_pop, f_empty, f_full, f_busy, f_start;
    logic [7:0]       f_din  [NCH];
    logic [7:0]       f_dout [NCH];
    logic [LVL_W-1:0] f_lvl  [NCH];
    logic             rx_acc;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign idx     = bus_addr[5:2];
    assign wr_any  = bus_sel & bus_wr & aligned;
    assign rd_any  = bus_sel & ~bus_wr & aligned;

    // Channel-specific queue hookup
    assign f_push[CH_RX] = rx_push;
    assign f_din[CH_RX]  = rx_byte;
    assign f_pop[CH_RX]  = rd_any & (idx == IX_RXD);
    assign f_push[CH_TX] = wr_any & (idx == IX_TXD);
    assign f_din[CH_TX]  = bus_wdata[7:0];
    assign f_pop[CH_TX]  = tx_req;

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            assign f_start[g] = wr_any & (idx == IX_FCTL) & bus_wdata[g + 1];
            assign f_clr[g]   = ~ctl_en | f_busy[g];

            i2c_regfront_flush u_flush (
                .clk   (clk),
                .rst_n (rst_n),
                .hold  (~ctl_en),
                .start (f_start[g]),
                .busy  (f_busy[g])
            );

            i2c_regfront_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (f_clr[g]),
                .push  (f_push[g]),
                .din   (f_din[g]),
                .pop   (f_pop[g]),
                .dout  (f_dout[g]),
                .empty (f_empty[g]),
                .full  (f_full[g]),
                .level (f_lvl[g])
            );

            AST_FLUSH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(f_busy[g]) |-> f_empty[g]); // R7
        end
    endgenerate

    assign rx_acc = rx_push & ~f_full[CH_RX] & ~f_clr[CH_RX];

    // Configuration registers: survive disable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en <= 1'b0;
            ctl_ie <= 1'b0;
            div_q  <= '0;
            tadr_q <= '0;
            dcnt_q <= '0;
            cmd_q  <= '0;
            nib_q  <= 1'b0;
        end else if (wr_any) begin
            unique case (idx)
                IX_CTL: begin
                    ctl_en <= bus_wdata[7];
                    ctl_ie <= bus_wdata[5];
                end
                IX_DIV:  div_q  <= bus_wdata[7:0];
                IX_TADR: tadr_q <= bus_wdata[7:0];
                IX_DCNT: dcnt_q <= bus_wdata[7:0];
                IX_CMD:  cmd_q  <= bus_wdata[CMD_W-1:0];
                IX_FCTL: nib_q  <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    // Latched status: clear on write, set by events (set wins)
    always_comb begin
        st_nxt = st_q;
        if (wr_any && idx == IX_STAT) begin
            if (bus_wdata == 32'd0) begin
                st_nxt = '0;
            end else begin
                st_nxt.berr = st_q.berr & ~bus_wdata[1];
                st_nxt.pend = st_q.pend & ~bus_wdata[2];
                st_nxt.arb  = st_q.arb  & ~bus_wdata[3];
                st_nxt.stop = st_q.stop & ~bus_wdata[4];
            end
        end
        st_nxt.berr = st_nxt.berr | ev_bus_err;
        st_nxt.arb  = st_nxt.arb  | ev_arb_lost;
        st_nxt.stop = st_nxt.stop | ev_stop;
        st_nxt.nack = st_nxt.nack | ev_nack;
        st_nxt.pend = st_nxt.pend | ev_done | ev_nack | ev_bus_err;
        if (!ctl_en) st_nxt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= '0;
            rcnt_q <= '0;
            go_q   <= 1'b0;
        end else begin
            st_q <= st_nxt;
            go_q <= ctl_en & wr_any & (idx == IX_CMD);
            if (!ctl_en)                        rcnt_q <= '0;
            else if (wr_any && idx == IX_CMD)   rcnt_q <= '0;
            else if (rx_acc)                    rcnt_q <= rcnt_q + 8'd1;
        end
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (rd_any) begin
            unique case (idx)
                IX_CTL: begin
                    bus_rdata[7] = ctl_en;
                    bus_rdata[5] = ctl_ie;
                end
                IX_DIV:  bus_rdata[7:0] = div_q;
                IX_STAT: begin
                    bus_rdata[1] = st_q.berr;
                    bus_rdata[2] = st_q.pend;
                    bus_rdata[3] = st_q.arb;
                    bus_rdata[4] = st_q.stop;
                    bus_rdata[6] = bus_busy;
                end
                IX_TADR: bus_rdata[7:0] = tadr_q;
                IX_RXD:  bus_rdata[7:0] = f_dout[CH_RX];
                IX_CMD:  bus_rdata[CMD_W-1:0] = cmd_q;
                IX_FCTL: begin
                    bus_rdata[0] = nib_q;
                    bus_rdata[1] = f_busy[CH_RX];
                    bus_rdata[2] = f_busy[CH_TX];
                end
                IX_FSTAT: begin
                    bus_rdata[1]     = st_q.nack;
                    bus_rdata[2]     = ~f_empty[CH_RX];
                    bus_rdata[5]     = f_full[CH_TX];
                    bus_rdata[15:8]  = 8'(f_lvl[CH_RX]);
                    bus_rdata[23:16] = 8'(f_lvl[CH_TX]);
                end
                IX_DCNT: bus_rdata[7:0] = dcnt_q;
                IX_RCNT: bus_rdata[7:0] = rcnt_q;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign irq_o           = st_q.pend & ctl_ie;
    assign seq_en          = ctl_en;
    assign seq_clk_div     = div_q;
    assign seq_target      = tadr_q;
    assign seq_byte_cnt    = dcnt_q;
    assign seq_cmd         = cmd_q;
    assign seq_go          = go_q;
    assign seq_ignore_nack = nib_q;
    assign tx_byte         = f_dout[CH_TX];
    assign tx_valid        = ~f_empty[CH_TX];

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ctl_ie); // R10
    AST_OFF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> (f_empty == '1)); // R2
    AST_GO_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        seq_go |-> seq_en); // R11

endmodule

// File: tb/i2c_regfront_tb_top.sv
module i2c_regfront_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, seq_en, seq_go, seq_ignore_nack, tx_valid;
    logic [7:0]  seq_clk_div, seq_target, seq_byte_cnt, tx_byte;
    logic [15:0] seq_cmd;
    logic        tx_req = 0, rx_push = 0;
    logic [7:0]  rx_byte = '0;
    logic        ev_done = 0, ev_nack = 0, ev_bus_err = 0, ev_arb_lost = 0, ev_stop = 0;
    logic        bus_busy = 0;

    always #4 clk = ~clk;

    i2c_regfront dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .seq_en(seq_en), .seq_clk_div(seq_clk_div),
        .seq_target(seq_target), .seq_byte_cnt(seq_byte_cnt), .seq_cmd(seq_cmd),
        .seq_go(seq_go), .seq_ignore_nack(seq_ignore_nack), .tx_req(tx_req),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .rx_push(rx_push), .rx_byte(rx_byte),
        .ev_done(ev_done), .ev_nack(ev_nack), .ev_bus_err(ev_bus_err),
        .ev_arb_lost(ev_arb_lost), .ev_stop(ev_stop), .bus_busy(bus_busy)
    );

    int n_chk = 0, n_err = 0;

    // Reference model state
    logic [7:0]  tx_q[$], rx_q[$];
    logic        m_en = 0, m_ie = 0, m_nib = 0, m_go = 0;
    logic        m_berr = 0, m_pend = 0, m_arb = 0, m_stop = 0, m_nack = 0;
    logic [7:0]  m_div = 0, m_tadr = 0, m_dcnt = 0, m_rcnt = 0;
    logic [15:0] m_cmd = 0;
    int          m_rxfl = 0, m_txfl = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input int ix);
        logic [31:0] r = '0;
        case (ix)
            0: begin r[7] = m_en; r[5] = m_ie; end
            1: r[7:0] = m_div;
            2: begin r[1] = m_berr; r[2] = m_pend; r[3] = m_arb; r[4] = m_stop; r[6] = bus_busy; end
            3: r[7:0] = m_tadr;
            5: r[7:0] = (rx_q.size() > 0) ? rx_q[0] : 8'd0;
            6: r[15:0] = m_cmd;
            7: begin r[0] = m_nib; r[1] = (m_rxfl > 0); r[2] = (m_txfl > 0); end
            8: begin
                r[1] = m_nack; r[2] = (rx_q.size() > 0); r[5] = (tx_q.size() == 16);
                r[15:8] = 8'(rx_q.size()); r[23:16] = 8'(tx_q.size());
            end
            9: r[7:0] = m_dcnt;
            10: r[7:0] = m_rcnt;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic void m_edge();
        logic sw = bus_sel && bus_wr && bus_addr[1:0] == 0;
        logic sr = bus_sel && !bus_wr && bus_addr[1:0] == 0;
        int   ix = int'(bus_addr[5:2]);
        logic [31:0] w = bus_wdata;
        m_go = sw && ix == 6 && m_en;
        if (!m_en) begin
            tx_q.delete(); rx_q.delete();
            {m_berr, m_pend, m_arb, m_stop, m_nack} = '0;
            m_rcnt = 0; m_rxfl = 0; m_txfl = 0;
        end else begin
            logic tfull = (tx_q.size() == 16);
            logic rfull = (rx_q.size() == 16);
            logic acc   = rx_push && !rfull && m_rxfl == 0;
            if (tx_req && tx_q.size() > 0) void'(tx_q.pop_front());
            if (sw && ix == 4 && !tfull) tx_q.push_back(w[7:0]);
            if (m_txfl > 0) tx_q.delete();
            if (sr && ix == 5 && rx_q.size() > 0) void'(rx_q.pop_front());
            if (acc) rx_q.push_back(rx_byte);
            if (m_rxfl > 0) rx_q.delete();
            if (sw && ix == 6) m_rcnt = 0; else if (acc) m_rcnt = m_rcnt + 1;
            if (sw && ix == 2) begin
                if (w == 0) {m_berr, m_pend, m_arb, m_stop, m_nack} = '0;
                else begin
                    if (w[1]) m_berr = 0; if (w[2]) m_pend = 0;
                    if (w[3]) m_arb = 0;  if (w[4]) m_stop = 0;
                end
            end
            m_berr |= ev_bus_err; m_arb |= ev_arb_lost; m_stop |= ev_stop;
            m_nack |= ev_nack; m_pend |= ev_done | ev_nack | ev_bus_err;
            if (m_rxfl > 0) m_rxfl--; else if (sw && ix == 7 && w[1]) m_rxfl = 2;
            if (m_txfl > 0) m_txfl--; else if (sw && ix == 7 && w[2]) m_txfl = 2;
        end
        if (sw) case (ix)
            0: begin m_en = w[7]; m_ie = w[5]; end
            1: m_div = w[7:0];
            3: m_tadr = w[7:0];
            6: m_cmd = w[15:0];
            7: m_nib = w[0];
            9: m_dcnt = w[7:0];
            default: ;
        endcase
    endfunction

    task automatic cmp_all();
        chk("R10 irq_o", 32'(irq_o), 32'(m_pend & m_ie));
        chk("R3 tx_valid", 32'(tx_valid), 32'(tx_q.size() > 0));
        chk("R3 tx_byte", 32'(tx_byte), (tx_q.size() > 0) ? 32'(tx_q[0]) : 32'd0);
        chk("R11 seq_go", 32'(seq_go), 32'(m_go));
        chk("R2 seq_en", 32'(seq_en), 32'(m_en));
        chk("R12 seq_clk_div", 32'(seq_clk_div), 32'(m_div));
        chk("R12 seq_target", 32'(seq_target), 32'(m_tadr));
        chk("R12 seq_byte_cnt", 32'(seq_byte_cnt), 32'(m_dcnt));
        chk("R11 seq_cmd", 32'(seq_cmd), 32'(m_cmd));
        chk("R8 seq_ignore_nack", 32'(seq_ignore_nack), 32'(m_nib));
    endtask

    task automatic step();
        @(posedge clk);
        m_edge();
        @(negedge clk);
        cmp_all();
    endtask

    task automatic wr(input int ix, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = 6'(ix * 4); bus_wdata = d;
        step();
        bus_sel = 0; bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic rd(input int ix, input string tag);
        bus_sel = 1; bus_wr = 0; bus_addr = 6'(ix * 4);
        #1;
        chk(tag, bus_rdata, m_read(ix));
        step();
        bus_sel = 0;
    endtask

    task automatic rxp(input logic [7:0] b);
        rx_push = 1; rx_byte = b; step(); rx_push = 0;
    endtask

    task automatic txpop();
        tx_req = 1; step(); tx_req = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", 32'(irq_o), 0);
        chk("R1 tx_valid in reset", 32'(tx_valid), 0);
        rst_n = 1;
        @(negedge clk);
        for (int i = 0; i <= 10; i++) rd(i, "R1 reset read");

        // Disabled: transmit write lost
        wr(4, 32'h55); rxp(8'h11);
        rd(8, "R2 disabled fifo status");
        chk("R2 tx_valid off", 32'(tx_valid), 0);

        wr(0, 32'hA0);
        wr(1, 32'h0000_1234); wr(3, 32'hA4); wr(9, 32'h0000_0107);
        rd(1, "R12 divider"); rd(3, "R12 target"); rd(9, "R12 count");

        // Transmit order and levels
        wr(4, 32'h01); wr(4, 32'h02); wr(4, 32'h03);
        rd(8, "R3 tx level");
        txpop(); rd(8, "R3 tx level after pop");
        txpop(); txpop(); txpop();
        // Overfill
        for (int i = 0; i < 17; i++) wr(4, 32'(8'h40 + i));
        rd(8, "R4 tx full");
        tx_req = 1; bus_sel = 1; bus_wr = 1; bus_addr = 6'd16; bus_wdata = 32'hEE;
        step();
        bus_sel = 0; bus_wr = 0; tx_req = 0;
        rd(8, "R4 drop while full and popping");
        for (int i = 0; i < 16; i++) txpop();
        chk("R4 tx empty after drain", 32'(tx_valid), 0);

        // Receive order and empty read
        wr(6, 32'h8A01);
        rxp(8'hC1); rxp(8'hC2);
        rd(8, "R5 rx level"); rd(10, "R11 rcnt");
        rd(5, "R5 rx first"); rd(5, "R5 rx second"); rd(5, "R5 empty read zero");
        for (int i = 0; i < 18; i++) rxp(8'(i));
        rd(8, "R6 rx full"); rd(10, "R6 rcnt stops");

        // Flush receive, traffic offered while busy
        wr(7, 32'h2);
        rx_push = 1; rx_byte = 8'h99;
        bus_sel = 1; bus_wr = 0; bus_addr = 6'd28; #1;
        chk("R7 rx flush busy", bus_rdata, m_read(7));
        step(); #1;
        chk("R7 rx flush busy 2", bus_rdata, m_read(7));
        step();
        bus_sel = 0; rx_push = 0;
        rd(7, "R7 flush bit cleared"); rd(8, "R7 rx emptied");
        wr(4, 32'h77); wr(4, 32'h78); wr(7, 32'h5);
        wr(4, 32'h79);
        rd(7, "R7 tx flush busy"); rd(8, "R7 tx emptied"); rd(7, "R8 nib readback");
        wr(4, 32'h7A); rd(8, "R7 tx accepts after flush");

        // Status and interrupts
        ev_done = 1; step(); ev_done = 0;
        rd(2, "R9 pending set");
        chk("R10 irq high", 32'(irq_o), 1);
        wr(0, 32'h80); chk("R10 irq masked", 32'(irq_o), 0);
        wr(0, 32'hA0);
        ev_bus_err = 1; ev_arb_lost = 1; ev_stop = 1; bus_busy = 1; step();
        ev_bus_err = 0; ev_arb_lost = 0; ev_stop = 0;
        rd(2, "R9 all flags");
        wr(2, 32'h8); rd(2, "R9 w1c arb");
        ev_nack = 1; step(); ev_nack = 0;
        rd(8, "R13 nack flag"); wr(2, 32'h4); rd(2, "R9 w1c pend");
        rd(8, "R13 nack survives w1c");
        bus_sel = 1; bus_wr = 1; bus_addr = 6'd8; bus_wdata = 32'h4; ev_done = 1;
        step(); bus_sel = 0; bus_wr = 0; ev_done = 0;
        rd(2, "R9 set wins over clear");
        wr(2, 32'h0); rd(2, "R9 zero write clears"); rd(8, "R13 nack cleared");
        bus_busy = 0;

        // Command strobe and disable
        rxp(8'h21); wr(6, 32'h1234); rd(10, "R11 rcnt reset"); step();
        wr(4, 32'h31); ev_done = 1; step(); ev_done = 0;
        wr(0, 32'h00); step();
        rd(8, "R2 disable clears"); rd(2, "R2 status cleared"); rd(1, "R2 config kept");
        wr(6, 32'h5555); rd(6, "R11 cmd stored, no go while off");

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule